// File: doc/BRIEF.md
# Infrared Transceiver Mode and LED Drive Controller

This block is the digital control core of an infrared transceiver that serves both a serial data link and a universal remote-control emitter. It watches three pins: a shutdown input and two transmit-data inputs, one for the data link and one for remote control. It decides which of the two emitters is lit, whether the receiver runs, and whether the receive-data pin is driven or floated. Every pulse width is measured in cycles of the block clock. The thresholds come from a clock-frequency parameter and from microsecond parameters.

The operating mode is set through the same pins, with no register access. A short pulse on the shutdown pin acts as a programming strobe. Where that pulse ends, the levels on the transmit pins select low-bandwidth link mode, high-bandwidth link mode, or single-input remote-control mode. A long shutdown pulse powers the receive path down, and on exit the mode returns to low bandwidth. Pulses of intermediate width are treated as glitches. A watchdog on each transmit input stops an input that is stuck high from keeping its emitter on.

Top module: `ir_xcvr_ctrl`

## Requirements
- R1: After reset, mode_o reads 2'b00 (low-bandwidth link), both LED enables are low, and rx_en_o and rx_oe_o are high.
- R2: mode_o encodes 2'b00 = low-bandwidth link, 2'b01 = high-bandwidth link and 2'b10 = remote control. On the first cycle sd_i is sampled low after it was high for 1 to PROG_CYC consecutive cycles (PROG_CYC = CLK_MHZ*PROG_US), with txd_rc_i low, mode_o becomes 2'b01 if txd_ir_i is high in that cycle and 2'b00 if it is low. The new value is visible one clock later.
- R3: On the same programming edge, if txd_rc_i is high, mode_o becomes 2'b10 whatever the level of txd_ir_i.
- R4: A shutdown pulse of more than PROG_CYC and fewer than SHUT_CYC cycles (SHUT_CYC = CLK_MHZ*SHUT_US) leaves mode_o unchanged and never disables the receiver.
- R5: Once sd_i has been high for SHUT_CYC consecutive sampled cycles, rx_en_o and rx_oe_o are low for as long as sd_i stays high. When such a pulse ends, mode_o returns to 2'b00 one clock after the first low sample.
- R6: While sd_i is high, ir_led_o and rc_led_o are both low.
- R7: With sd_i low and mode_o not 2'b10, txd_ir_i alone lights ir_led_o and txd_rc_i alone lights rc_led_o. With both inputs high, or both low, both LED enables are low.
- R8: With sd_i low and mode_o 2'b10, ir_led_o stays low. rc_led_o is high when exactly one transmit input is high, and low when both are high.
- R9: A transmit input that has been high for STUCK_CYC consecutive sampled cycles (STUCK_CYC = CLK_MHZ*STUCK_US) no longer lights any LED until it is sampled low. A later high level lights the LED again.
- R10: rx_en_o and rx_oe_o are high whenever the block is not in complete shutdown, including during programming pulses and glitch pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, CLK_MHZ MHz |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sd_i | input | 1 | Shutdown / programming strobe, active high |
| txd_ir_i | input | 1 | Data-link transmit data, active high |
| txd_rc_i | input | 1 | Remote-control transmit data, active high |
| ir_led_o | output | 1 | Data-link emitter enable |
| rc_led_o | output | 1 | Remote-control emitter enable |
| rx_en_o | output | 1 | Receiver and photodiode enable |
| rx_oe_o | output | 1 | Receive-data (active-low) pin output enable; low floats the pin |
| mode_o | output | 2 | Current mode: 00 low-bandwidth link, 01 high-bandwidth link, 10 remote control |

## Verification
The bench tests the programming window at its edges. A strobe of exactly PROG_CYC cycles must latch a mode, and one of PROG_CYC+1 cycles must not; an off-by-one comparator shows up as a wrong mode_o code. A strobe of SHUT_CYC-1 cycles must leave the receiver on, while a longer one must float the receive pin and reset the mode to low bandwidth on exit. A design that missed the reset on exit would keep its high-bandwidth or remote-control code.

The stuck-high watchdog is driven past STUCK_CYC on each input and then re-armed. This catches a counter that never clears, or one that cuts the LED a cycle early or late. Remote-control mode is checked with the data-link input alone, which must light the remote-control emitter. A swapped routing would light the wrong LED there.

// File: rtl/ir_xcvr_pkg.sv
package ir_xcvr_pkg;

  typedef enum logic [1:0] {
    MODE_SIR  = 2'b00,
    MODE_FAST = 2'b01,
    MODE_RC   = 2'b10
  } ir_mode_e;

  localparam int unsigned NUM_TX = 2;
  localparam int unsigned TX_IR  = 0;
  localparam int unsigned TX_RC  = 1;

endpackage

// File: rtl/ir_hold_timer.sv
module ir_hold_timer #(
  parameter int unsigned LIMIT = 4,
  localparam int unsigned CW = $clog2(LIMIT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          level_i,
  output logic [CW-1:0] count_o,
  output logic          expired_o
);

  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  // consecutive high samples, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
    end else if (!level_i) begin
      count_o <= '0;
    end else if (count_o != LIM) begin
      count_o <= count_o + 1'b1;
    end
  end

  assign expired_o = (count_o == LIM);

endmodule

// File: rtl/ir_mode_latch.sv
module ir_mode_latch
  import ir_xcvr_pkg::*;
#(
  parameter int unsigned PROG_CYC = 20,
  parameter int unsigned SHUT_CYC = 120,
  localparam int unsigned CW = $clog2(SHUT_CYC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sd_i,
  input  logic          txd_ir_i,
  input  logic          txd_rc_i,
  input  logic [CW-1:0] sd_count_i,
  input  logic          sd_expired_i,
  output ir_mode_e      mode_o
);

  localparam logic [CW-1:0] PROG_LIM = CW'(PROG_CYC);

  logic     sd_fall;
  logic     prog_pulse;
  ir_mode_e mode_d;

  // count still holds the pulse width on the first low sample
  assign sd_fall    = !sd_i && (sd_count_i != '0);
  assign prog_pulse = (sd_count_i <= PROG_LIM);

  always_comb begin
    mode_d = mode_o;
    if (sd_fall) begin
      if (prog_pulse) begin
        if (txd_rc_i)      mode_d = MODE_RC;
        else if (txd_ir_i) mode_d = MODE_FAST;
        else               mode_d = MODE_SIR;
      end else if (sd_expired_i) begin
        mode_d = MODE_SIR;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_o <= MODE_SIR;
    else         mode_o <= mode_d;
  end

endmodule

// File: rtl/ir_led_drive.sv
module ir_led_drive
  import ir_xcvr_pkg::*;
(
  input  logic     sd_i,
  input  ir_mode_e mode_i,
  input  logic     txd_ir_i,
  input  logic     txd_rc_i,
  input  logic     ir_stuck_i,
  input  logic     rc_stuck_i,
  output logic     ir_led_o,
  output logic     rc_led_o
);

  logic ir_solo, rc_solo;

  assign ir_solo = txd_ir_i && !txd_rc_i && !ir_stuck_i;
  assign rc_solo = txd_rc_i && !txd_ir_i && !rc_stuck_i;

  always_comb begin
    ir_led_o = 1'b0;
    rc_led_o = 1'b0;
    if (!sd_i) begin
      if (mode_i == MODE_RC) begin
        rc_led_o = ir_solo || rc_solo;
      end else begin
        ir_led_o = ir_solo;
        rc_led_o = rc_solo;
      end
    end
  end

endmodule

// File: rtl/ir_xcvr_ctrl.sv
module ir_xcvr_ctrl
  import ir_xcvr_pkg::*;
#(
  parameter int unsigned CLK_MHZ  = 48,
  parameter int unsigned PROG_US  = 5,
  parameter int unsigned SHUT_US  = 30,
  parameter int unsigned STUCK_US = 50
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sd_i,
  input  logic       txd_ir_i,
  input  logic       txd_rc_i,
  output logic       ir_led_o,
  output logic       rc_led_o,
  output logic       rx_en_o,
  output logic       rx_oe_o,
  output logic [1:0] mode_o
);

  localparam int unsigned PROG_CYC  = CLK_MHZ * PROG_US;
  localparam int unsigned SHUT_CYC  = CLK_MHZ * SHUT_US;
  localparam int unsigned STUCK_CYC = CLK_MHZ * STUCK_US;
  localparam int unsigned SD_CW     = $clog2(SHUT_CYC + 1);
  localparam int unsigned TX_CW     = $clog2(STUCK_CYC + 1);

  logic [SD_CW-1:0]  sd_count;
  logic              sd_expired;
  logic              shut;
  logic [NUM_TX-1:0] tx_level;
  logic [NUM_TX-1:0] tx_stuck;
  ir_mode_e          mode_q;

  assign tx_level[TX_IR] = txd_ir_i;
  assign tx_level[TX_RC] = txd_rc_i;

  ir_hold_timer #(.LIMIT(SHUT_CYC)) u_sd_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .level_i   (sd_i),
    .count_o   (sd_count),
    .expired_o (sd_expired)
  );

  for (genvar g = 0; g < NUM_TX; g++) begin : g_tx_wd
    logic [TX_CW-1:0] tx_count;
    ir_hold_timer #(.LIMIT(STUCK_CYC)) u_tx_timer (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .level_i   (tx_level[g]),
      .count_o   (tx_count),
      .expired_o (tx_stuck[g])
    );
  end

  ir_mode_latch #(.PROG_CYC(PROG_CYC), .SHUT_CYC(SHUT_CYC)) u_mode (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sd_i         (sd_i),
    .txd_ir_i     (txd_ir_i),
    .txd_rc_i     (txd_rc_i),
    .sd_count_i   (sd_count),
    .sd_expired_i (sd_expired),
    .mode_o       (mode_q)
  );

  ir_led_drive u_drive (
    .sd_i       (sd_i),
    .mode_i     (mode_q),
    .txd_ir_i   (txd_ir_i),
    .txd_rc_i   (txd_rc_i),
    .ir_stuck_i (tx_stuck[TX_IR]),
    .rc_stuck_i (tx_stuck[TX_RC]),
    .ir_led_o   (ir_led_o),
    .rc_led_o   (rc_led_o)
  );

  assign shut    = sd_i && sd_expired;
  assign rx_en_o = !shut;
  assign rx_oe_o = !shut;
  assign mode_o  = mode_q;

endmodule

// File: rtl/ir_xcvr_ctrl_chk.sv
module ir_xcvr_ctrl_chk #(
  parameter int unsigned SHUT_CYC  = 120,
  parameter int unsigned STUCK_CYC = 200
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sd_i,
  input logic       txd_ir_i,
  input logic       txd_rc_i,
  input logic       ir_led_o,
  input logic       rc_led_o,
  input logic       rx_en_o,
  input logic       rx_oe_o,
  input logic [1:0] mode_o
);

  int unsigned sd_run, ir_run, rc_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sd_run <= 0;
      ir_run <= 0;
      rc_run <= 0;
    end else begin
      sd_run <= !sd_i ? 0 : (sd_run < SHUT_CYC ? sd_run + 1 : sd_run);
      ir_run <= !txd_ir_i ? 0 : (ir_run < STUCK_CYC ? ir_run + 1 : ir_run);
      rc_run <= !txd_rc_i ? 0 : (rc_run < STUCK_CYC ? rc_run + 1 : rc_run);
    end
  end

  p_mode_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'b11);

  p_mode_only_on_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sd_i && !$past(sd_i)) && !(!sd_i && $past(sd_i)) |=> $stable(mode_o));

  p_shut_floats_rx_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sd_i && sd_run >= SHUT_CYC) |-> (!rx_en_o && !rx_oe_o));

  p_shut_exit_sir_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sd_i && sd_run >= SHUT_CYC) |=> (mode_o == 2'b00));

  p_sd_leds_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_i |-> (!ir_led_o && !rc_led_o));

  p_leds_exclusive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ir_led_o && rc_led_o));

  p_rc_mode_no_ir_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b10) |-> !ir_led_o);

  p_ir_stuck_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txd_ir_i && !txd_rc_i && ir_run >= STUCK_CYC) |-> (!ir_led_o && !rc_led_o));

  p_rc_stuck_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txd_rc_i && !txd_ir_i && rc_run >= STUCK_CYC) |-> !rc_led_o);

  p_rx_on_when_sd_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sd_i |-> (rx_en_o && rx_oe_o));

endmodule

bind ir_xcvr_ctrl ir_xcvr_ctrl_chk #(
  .SHUT_CYC  (SHUT_CYC),
  .STUCK_CYC (STUCK_CYC)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sd_i     (sd_i),
  .txd_ir_i (txd_ir_i),
  .txd_rc_i (txd_rc_i),
  .ir_led_o (ir_led_o),
  .rc_led_o (rc_led_o),
  .rx_en_o  (rx_en_o),
  .rx_oe_o  (rx_oe_o),
  .mode_o   (mode_o)
);

// File: tb/ir_xcvr_ctrl_bench.sv
`timescale 1ns/1ps
module ir_xcvr_ctrl_bench;

  localparam int CLK_MHZ = 4;
  localparam int PROG    = CLK_MHZ * 5;
  localparam int SHUT    = CLK_MHZ * 30;
  localparam int STUCK   = CLK_MHZ * 50;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sd = 1'b0, tir = 1'b0, trc = 1'b0;
  logic       ir_led, rc_led, rx_en, rx_oe;
  logic [1:0] mode;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  // reference model state
  int m_mode = 0;
  int sd_w = 0, ir_w = 0, rc_w = 0;

  always #2 clk = ~clk;

  ir_xcvr_ctrl #(.CLK_MHZ(CLK_MHZ)) u_ir_xcvr_ctrl (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .sd_i     (sd),
    .txd_ir_i (tir),
    .txd_rc_i (trc),
    .ir_led_o (ir_led),
    .rc_led_o (rc_led),
    .rx_en_o  (rx_en),
    .rx_oe_o  (rx_oe),
    .mode_o   (mode)
  );

  function automatic logic [5:0] expect_now(input logic s, input logic a, input logic b);
    logic e_ir, e_rc, e_rx, solo_a, solo_b;
    e_ir = 1'b0;
    e_rc = 1'b0;
    e_rx = !(s && sd_w >= SHUT);
    solo_a = a && !b && (ir_w < STUCK);
    solo_b = b && !a && (rc_w < STUCK);
    if (!s) begin
      if (m_mode == 2) e_rc = solo_a || solo_b;
      else begin
        e_ir = solo_a;
        e_rc = solo_b;
      end
    end
    return {e_ir, e_rc, e_rx, e_rx, 2'(m_mode)};
  endfunction

  task automatic compare(input string req, input logic [5:0] exp_v);
    logic [5:0] act;
    act = {ir_led, rc_led, rx_en, rx_oe, mode};
    vectors++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s t=%0t act=%b exp=%b (ir_led rc_led rx_en rx_oe mode)", req, $time, act, exp_v);
    end
  endtask

  task automatic step(input logic s, input logic a, input logic b, input string req);
    @(negedge clk);
    sd = s; tir = a; trc = b;
    #1;
    compare(req, expect_now(s, a, b));
    @(posedge clk);
    if (!s && sd_w > 0) begin
      if (sd_w <= PROG)      m_mode = b ? 2 : (a ? 1 : 0);
      else if (sd_w >= SHUT) m_mode = 0;
    end
    sd_w = s ? sd_w + 1 : 0;
    ir_w = a ? ir_w + 1 : 0;
    rc_w = b ? rc_w + 1 : 0;
  endtask

  task automatic pulse(input int width, input logic a_end, input logic b_end, input string req);
    for (int i = 0; i < width; i++) step(1'b1, 1'b0, 1'b0, req);
    step(1'b0, a_end, b_end, req);
    step(1'b0, 1'b0, 1'b0, req);
    step(1'b0, 1'b0, 1'b0, req);
  endtask

  task automatic table4(input string req);
    step(1'b0, 1'b1, 1'b0, req);
    step(1'b0, 1'b0, 1'b1, req);
    step(1'b0, 1'b1, 1'b1, req);
    step(1'b0, 1'b0, 1'b0, req);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #1 compare("R1", 6'b001100);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) step(1'b0, 1'b0, 1'b0, "R1");

    // R7: low-bandwidth truth table
    table4("R7");

    // R6 / R10: sd high with data inputs active, short enough to be a glitch
    for (int i = 0; i < PROG + 4; i++) step(1'b1, 1'b1, i[0], "R6");
    step(1'b0, 1'b0, 1'b0, "R10");
    step(1'b0, 1'b0, 1'b0, "R4");

    // R2: program high bandwidth, exactly PROG cycles
    pulse(PROG, 1'b1, 1'b0, "R2");
    table4("R7");

    // R4: one cycle too long, and just below shutdown
    pulse(PROG + 1, 1'b0, 1'b0, "R4");
    pulse(SHUT - 1, 1'b0, 1'b0, "R4");
    // R2: back to low bandwidth with a one-cycle strobe
    pulse(1, 1'b0, 1'b0, "R2");

    // R3: remote-control mode, ir also high at the edge
    pulse(3, 1'b1, 1'b1, "R3");
    table4("R8");
    step(1'b0, 1'b1, 1'b0, "R8");

    // R5: complete shutdown, return to low bandwidth
    pulse(SHUT + 8, 1'b1, 1'b0, "R5");
    table4("R7");

    // R9: stuck ir input, then re-arm
    for (int i = 0; i < STUCK + 10; i++) step(1'b0, 1'b1, 1'b0, "R9");
    step(1'b0, 1'b0, 1'b0, "R9");
    repeat (3) step(1'b0, 1'b1, 1'b0, "R9");
    // R9: stuck rc input
    for (int i = 0; i < STUCK + 10; i++) step(1'b0, 1'b0, 1'b1, "R9");
    step(1'b0, 1'b0, 1'b0, "R9");
    step(1'b0, 1'b0, 1'b1, "R9");
    // R9 in remote-control mode through the ir input
    pulse(2, 1'b0, 1'b1, "R3");
    for (int i = 0; i < STUCK + 5; i++) step(1'b0, 1'b1, 1'b0, "R9");
    step(1'b0, 1'b0, 1'b0, "R9");

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule